// File: doc/BRIEF.md
# Pulse-Synchronized Tracking ADC Sequencer

This block runs the measurement cycle for a pulsed, rectified voltage. The voltage is sampled through an analog comparator and a tracking DAC. Each PWM rising edge opens a new cycle. From that edge, one shared cycle counter drives two timers:

- A watchdog timer, which checks that the filtered comparator output changes state (the pulse has arrived) within a programmable number of clocks.
- A track-start timer, which holds tracking off until the analog front end has had time to settle.

If the watchdog expires without seeing a comparator transition, the DAC register is loaded with the code held at the end of the previous cycle. Tracking then continues from that point. Otherwise the code stays at zero until tracking starts.

While tracking, the code moves one LSB per clock, towards the comparator's decision. A deglitch filter on the raw comparator input removes short spurious pulses before the sequencer sees them. At the PWM falling edge the code is frozen, and a one-cycle valid strobe marks the measurement. Any watchdog expiry sets a sticky flag, which stays set until a clear input is pulsed.

Top module: `pulse_track_seq`

## Requirements
- R1: After reset the DAC code is 0, the valid strobe is low and the timeout flag is low.
- R2: A PWM rising edge (PWM sampled high at a clock edge after being low at the previous one) restarts the cycle counter and forces the DAC code to 0 at that same clock edge.
- R3: The filtered comparator level follows a raw level change only after the raw input has differed from it on `dgl_len_i` consecutive clock edges. Shorter pulses leave it unchanged. A `dgl_len_i` of 0 selects the default length of 4.
- R4: If no filtered transition has been seen when the counter reaches `wdt_lim_i`, the edge `wdt_lim_i`+1 clocks after the rising edge loads the previous cycle's held code into the DAC register and sets the timeout flag.
- R5: If a filtered transition is seen before the watchdog expires, no preload occurs, the flag is untouched, and the code stays 0 until tracking starts.
- R6: Tracking starts S+1 clocks after the rising edge, and its first step is at S+2, where S is `start_lim_i` if that exceeds `wdt_lim_i`, and `wdt_lim_i`+1 otherwise.
- R7: While tracking, each clock adds 1 to the code when the filtered comparator is 0 and subtracts 1 when it is 1, saturating at 0 and at 1023.
- R8: At a PWM falling edge during a cycle, the code is frozen and becomes the previous code for the next cycle, and `valid_o` is high for exactly one clock. The code does not change again until the next rising edge.
- R9: The timeout flag stays set until `tmo_clr_i` is high at a clock edge. A new expiry at the same edge wins over the clear.
- R10: A falling edge that arrives before the watchdog expires freezes the code at 0 and leaves the timeout flag clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwm_i | input | 1 | PWM signal, synchronous to clk |
| cmp_raw_i | input | 1 | Raw comparator output, synchronous to clk |
| wdt_lim_i | input | 12 | Watchdog expiry count |
| start_lim_i | input | 12 | Track-start count |
| dgl_len_i | input | 4 | Deglitch length in clocks; 0 selects the default |
| tmo_clr_i | input | 1 | Clears the sticky timeout flag |
| dac_code_o | output | 10 | Tracking DAC code |
| valid_o | output | 1 | One-cycle strobe with the held code |
| tmo_flag_o | output | 1 | Sticky watchdog-expiry flag |

## Verification
Cycles are run under several comparator patterns:
- A comparator held low, and one held high, with no transition. These drive the watchdog preload and tracking in both directions, including saturation at both ends of the code range.
- A genuine pulse long enough to pass the filter. This shows a seen transition suppressing the preload, so tracking starts from zero rather than from the previous code.
- A pulse shorter than the filter length. This must still end in a timeout, which separates a working deglitcher from a pass-through.
- A three-clock pulse run with a filter length of 2 and then of 0 (default 4). This tells the programmed length apart from the default.

Further cycles use a track-start limit below the watchdog limit, and a PWM pulse that ends before the watchdog expires. These separate the clamped start time and the early hold.

// File: rtl/pts_pkg.sv
package pts_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ARM   = 2'd1,
      ST_TRACK = 2'd2
   } seq_state_t;

endpackage

// File: rtl/pts_deglitch.sv
module pts_deglitch #(
   parameter int DG_W    = 4,
   parameter int DEF_LEN = 4,
   parameter bit ENABLE  = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            raw_i,
   input  logic [DG_W-1:0] len_i,
   output logic            filt_o,
   output logic            chg_o
);

   initial begin
      if (DG_W < 1 || DG_W > 16) $error("pts_deglitch: DG_W out of range");
      if (DEF_LEN < 1 || DEF_LEN >= (1 << DG_W)) $error("pts_deglitch: DEF_LEN out of range");
   end

   logic filt_q;
   logic filt_d;

   generate
      if (ENABLE) begin : g_filter
         logic [DG_W-1:0] run_q;
         logic [DG_W-1:0] len_eff;

         assign len_eff = (len_i == '0) ? DG_W'(DEF_LEN) : len_i;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               run_q  <= '0;
               filt_q <= 1'b0;
            end else if (raw_i == filt_q) begin
               run_q <= '0;
            end else if (run_q == len_eff - DG_W'(1)) begin
               run_q  <= '0;
               filt_q <= raw_i;
            end else begin
               run_q <= run_q + DG_W'(1);
            end
         end
      end else begin : g_bypass
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) filt_q <= 1'b0;
            else        filt_q <= raw_i;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) filt_d <= 1'b0;
      else        filt_d <= filt_q;
   end

   assign filt_o = filt_q;
   assign chg_o  = filt_q ^ filt_d;

endmodule

// File: rtl/pts_cycle_timer.sv
module pts_cycle_timer #(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart_i,
   input  logic             run_i,
   input  logic [CNT_W-1:0] wdt_lim_i,
   input  logic [CNT_W-1:0] start_lim_i,
   output logic             wdt_hit_o,
   output logic             start_hit_o
);

   localparam int EW = CNT_W + 1;
   localparam logic [EW-1:0] CNT_MAX = {EW{1'b1}};

   initial begin
      if (CNT_W < 2 || CNT_W > 30) $error("pts_cycle_timer: CNT_W out of range");
   end

   logic [EW-1:0] cnt_q;
   logic [EW-1:0] wdt_ext;
   logic [EW-1:0] start_ext;
   logic [EW-1:0] start_eff;

   assign wdt_ext   = {1'b0, wdt_lim_i};
   assign start_ext = {1'b0, start_lim_i};
   assign start_eff = (start_ext > wdt_ext) ? start_ext : wdt_ext + EW'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         cnt_q <= '0;
      else if (restart_i)                 cnt_q <= '0;
      else if (run_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + EW'(1);
   end

   assign wdt_hit_o   = run_i && (cnt_q == wdt_ext);
   assign start_hit_o = run_i && (cnt_q == start_eff);

endmodule

// File: rtl/pts_code_reg.sv
module pts_code_reg #(
   parameter int CODE_W   = 10,
   parameter bit SATURATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear_i,
   input  logic              preload_i,
   input  logic              step_i,
   input  logic              down_i,
   input  logic              hold_i,
   output logic [CODE_W-1:0] code_o
);

   localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};

   initial begin
      if (CODE_W < 2 || CODE_W > 16) $error("pts_code_reg: CODE_W out of range");
   end

   logic [CODE_W-1:0] code_q;
   logic [CODE_W-1:0] prev_q;
   logic [CODE_W-1:0] step_val;

   generate
      if (SATURATE) begin : g_sat
         always_comb begin
            if (down_i) step_val = (code_q == '0) ? '0 : code_q - CODE_W'(1);
            else        step_val = (code_q == CODE_MAX) ? CODE_MAX : code_q + CODE_W'(1);
         end
      end else begin : g_wrap
         always_comb begin
            if (down_i) step_val = code_q - CODE_W'(1);
            else        step_val = code_q + CODE_W'(1);
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q <= '0;
         prev_q <= '0;
      end else begin
         if (clear_i)        code_q <= '0;
         else if (preload_i) code_q <= prev_q;
         else if (step_i)    code_q <= step_val;
         if (hold_i)         prev_q <= code_q;
      end
   end

   assign code_o = code_q;

endmodule

// File: rtl/pulse_track_seq.sv
module pulse_track_seq #(
   parameter int CODE_W      = 10,
   parameter int CNT_W       = 12,
   parameter int DG_W        = 4,
   parameter int DG_DEF      = 4,
   parameter bit DG_ENABLE   = 1'b1,
   parameter bit SAT_ENABLE  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pwm_i,
   input  logic              cmp_raw_i,
   input  logic [CNT_W-1:0]  wdt_lim_i,
   input  logic [CNT_W-1:0]  start_lim_i,
   input  logic [DG_W-1:0]   dgl_len_i,
   input  logic              tmo_clr_i,
   output logic [CODE_W-1:0] dac_code_o,
   output logic              valid_o,
   output logic              tmo_flag_o
);
   import pts_pkg::*;

   seq_state_t state_q;
   logic       pwm_q;
   logic       rise_w;
   logic       fall_w;
   logic       seen_q;
   logic       filt_w;
   logic       chg_w;
   logic       wdt_hit_w;
   logic       start_hit_w;
   logic       tmo_evt_w;
   logic       hold_w;
   logic       step_w;
   logic       valid_q;
   logic       flag_q;
   logic       in_arm;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pwm_q <= 1'b0;
      else        pwm_q <= pwm_i;
   end

   assign rise_w = pwm_i & ~pwm_q;
   assign fall_w = ~pwm_i & pwm_q;
   assign in_arm = (state_q == ST_ARM) && !rise_w && !fall_w;

   pts_deglitch #(
      .DG_W    (DG_W),
      .DEF_LEN (DG_DEF),
      .ENABLE  (DG_ENABLE)
   ) u_dgl (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw_i  (cmp_raw_i),
      .len_i  (dgl_len_i),
      .filt_o (filt_w),
      .chg_o  (chg_w)
   );

   pts_cycle_timer #(
      .CNT_W (CNT_W)
   ) u_tmr (
      .clk         (clk),
      .rst_n       (rst_n),
      .restart_i   (rise_w),
      .run_i       (state_q == ST_ARM),
      .wdt_lim_i   (wdt_lim_i),
      .start_lim_i (start_lim_i),
      .wdt_hit_o   (wdt_hit_w),
      .start_hit_o (start_hit_w)
   );

   assign tmo_evt_w = in_arm && wdt_hit_w && !seen_q && !chg_w;
   assign hold_w    = fall_w && (state_q != ST_IDLE);
   assign step_w    = (state_q == ST_TRACK) && !rise_w && !fall_w;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         seen_q  <= 1'b0;
      end else if (rise_w) begin
         state_q <= ST_ARM;
         seen_q  <= 1'b0;
      end else if (hold_w) begin
         state_q <= ST_IDLE;
      end else if (in_arm) begin
         if (chg_w)       seen_q  <= 1'b1;
         if (start_hit_w) state_q <= ST_TRACK;
      end
   end

   pts_code_reg #(
      .CODE_W   (CODE_W),
      .SATURATE (SAT_ENABLE)
   ) u_code (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear_i   (rise_w),
      .preload_i (tmo_evt_w),
      .step_i    (step_w),
      .down_i    (filt_w),
      .hold_i    (hold_w),
      .code_o    (dac_code_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         flag_q  <= 1'b0;
      end else begin
         valid_q <= hold_w;
         if (tmo_evt_w)      flag_q <= 1'b1;
         else if (tmo_clr_i) flag_q <= 1'b0;
      end
   end

   assign valid_o    = valid_q;
   assign tmo_flag_o = flag_q;

endmodule

// File: rtl/pts_checker.sv
module pts_checker #(
   parameter int CODE_W = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rise,
   input logic              fall,
   input logic [1:0]        state,
   input logic [CODE_W-1:0] code,
   input logic              valid,
   input logic              flag,
   input logic              clr,
   input logic              tmo_evt
);

   assert_valid_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      valid |=> !valid);

   assert_rise_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> (code == '0));

   assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !clr) |=> flag);

   assert_timeout_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_evt |=> flag);

   assert_step_size_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (state == 2'd2 && !rise && !fall) |=>
         ((code == $past(code)) || (code == $past(code) + CODE_W'(1)) ||
          ($past(code) == code + CODE_W'(1))));

   assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == 2'd0 && !rise) |=> $stable(code));

endmodule

bind pulse_track_seq pts_checker #(.CODE_W(CODE_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .rise    (rise_w),
   .fall    (fall_w),
   .state   (state_q),
   .code    (dac_code_o),
   .valid   (valid_o),
   .flag    (tmo_flag_o),
   .clr     (tmo_clr_i),
   .tmo_evt (tmo_evt_w)
);

// File: tb/pulse_track_seq_bench.sv
module pulse_track_seq_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pwm = 1'b0;
   logic        cmp = 1'b0;
   logic [11:0] wdt_lim = 12'd20;
   logic [11:0] start_lim = 12'd30;
   logic [3:0]  dgl_len = 4'd4;
   logic        clr = 1'b0;
   logic [9:0]  code;
   logic        valid;
   logic        flag;

   int checks = 0;
   int errors = 0;
   int exp_q[$];
   string tag_q[$];
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   pulse_track_seq u_pulse_track_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .pwm_i       (pwm),
      .cmp_raw_i   (cmp),
      .wdt_lim_i   (wdt_lim),
      .start_lim_i (start_lim),
      .dgl_len_i   (dgl_len),
      .tmo_clr_i   (clr),
      .dac_code_o  (code),
      .valid_o     (valid),
      .tmo_flag_o  (flag)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // One PWM pulse of h clocks; raw comparator goes high at offset hi_at and low at lo_at.
   task automatic pulse(input int h, input int hi_at, input int lo_at,
                        input int pre_exp, input int held_exp, input string req);
      exp_q.push_back(held_exp);
      tag_q.push_back(req);
      @(negedge clk);
      pwm = 1'b1;
      for (int i = 0; i < h; i++) begin
         @(negedge clk);
         if (i == 0) check("R2 code cleared on rise", code, 0);
         if (i == int'(wdt_lim) + 1 && pre_exp >= 0)
            check("R4/R5 code after watchdog point", code, pre_exp);
         if (i == hi_at) cmp = 1'b1;
         if (i == lo_at) cmp = 1'b0;
      end
      pwm = 1'b0;
      repeat (6) @(negedge clk);
   endtask

   // Scoreboard monitor
   initial begin
      bit prev_v = 1'b0;
      forever begin
         @(negedge clk);
         if (valid) begin
            if (exp_q.size() == 0) begin
               check("R8 unexpected valid", 1, 0);
            end else begin
               int e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               check(t, code, e);
            end
         end
         if (prev_v) check("R8 valid one cycle", valid, 0);
         prev_v = valid;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset code", code, 0);
      check("R1 reset valid", valid, 0);
      check("R1 reset flag", flag, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R4 R7: timeout, preload 0, track up 28 steps
      pulse(60, -1, -1, 0, 28, "R4 R7 timeout up");
      check("R4 flag set", flag, 1);
      // R9 clear
      clr = 1'b1; @(negedge clk); clr = 1'b0;
      check("R9 flag cleared", flag, 0);
      // R5: genuine pulse seen, no preload of 28
      pulse(60, 2, 10, 0, 28, "R5 seen track from 0");
      check("R5 no flag", flag, 0);
      // R3: short glitch rejected -> timeout preload 28
      pulse(60, 2, 4, 28, 56, "R3 glitch rejected");
      check("R3 flag from glitch cycle", flag, 1);
      // R7 down: comparator steady high
      cmp = 1'b1;
      repeat (10) @(negedge clk);
      pulse(50, -1, -1, 56, 38, "R7 track down");
      pulse(120, -1, -1, 38, 0, "R7 saturate at 0");
      cmp = 1'b0;
      repeat (10) @(negedge clk);
      pulse(1100, -1, -1, 0, 1023, "R7 saturate at 1023");
      // R6: start below watchdog -> S = 21
      start_lim = 12'd10;
      cmp = 1'b1;
      repeat (10) @(negedge clk);
      pulse(60, -1, -1, 1023, 986, "R6 clamped start");
      start_lim = 12'd30;
      cmp = 1'b0;
      repeat (10) @(negedge clk);
      // R10: early fall
      clr = 1'b1; @(negedge clk); clr = 1'b0;
      pulse(15, -1, -1, -1, 0, "R10 early hold");
      check("R10 no flag", flag, 0);
      // R3: programmed length 2 passes a 3-clock pulse
      dgl_len = 4'd2;
      pulse(60, 2, 5, 0, 28, "R3 length 2 passes");
      check("R3 length 2 no flag", flag, 0);
      // R3: length 0 selects default 4, same pulse rejected
      dgl_len = 4'd0;
      pulse(60, 2, 5, 28, 56, "R3 default length rejects");
      check("R3 default length flag", flag, 1);
      // R9: flag held without clear
      repeat (5) @(negedge clk);
      check("R9 flag sticky", flag, 1);
      check("R8 scoreboard drained", exp_q.size(), 0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule